// File: doc/BRIEF.md
# EDID Block Fetch Sequencer

This engine reads a display's identification data over a display data channel, one 128-byte block at a time. It drives a simple command port: it clears the receive FIFO, issues a read command carrying a segment, an in-segment offset and a byte count, and waits for the channel to report completion. The returned bytes are then pulled from the FIFO one per cycle and written out through a block-buffer port, while a running modulo-256 sum is kept. The bit-level I2C engine sits outside this block and is seen only as the command, done and FIFO-data signals.

A single start pulse runs the whole sequence. The base block comes first. If its checksum holds, the extension-flag byte is read and clamped, and that many extension blocks follow. A block that fails is re-read a limited number of times. A base-block failure ends the run with an error code. An extension-block failure ends the run cleanly with the count of extension blocks that did arrive intact. A one-cycle done pulse carries the final status and the valid extension count.

Top module: `edid_fetch_seq`

## Requirements
- R1: Every read command asks for between 1 and 16 bytes (`ddc_count`), and each block is covered by 8 consecutive commands whose offsets advance by the previous count.
- R2: A command for byte p of block k addresses absolute offset k*128+p. `ddc_segment` carries the bits above bit 7 of that offset and `ddc_offset` the low 8 bits. The first command of block 2 therefore carries segment 1 and offset 0.
- R3: `ddc_fifo_clr` pulses in the cycle directly before every `ddc_cmd_start` pulse. After `ddc_done`, exactly the commanded number of bytes is read from the FIFO, one per cycle.
- R4: If `ddc_done` does not arrive within TIMEOUT_CYC cycles of waiting, the attempt fails with the timeout code.
- R5: A block whose 128 bytes do not sum to zero modulo 256, or whose attempt timed out, is re-read from its first byte up to 2 more times. A later successful attempt lets the run continue normally.
- R6: The number of extension blocks fetched is the base block's byte 126, clamped to 4.
- R7: When an extension block still fails after its last attempt, fetching stops. The status is 0 (ok) and `ext_count` is the number of extension blocks before it.
- R8: When the base block still fails after its last attempt, the status is the last attempt's error code and `ext_count` is 0.
- R9: Each drained byte is written with `buf_blk` = block index and `buf_addr` = byte index within the block. `done` is a one-cycle pulse whose `status` is 0 for ok, 1 for timeout and 2 for checksum error.
- R10: `busy` is high from the cycle after an accepted start until the done pulse, and a start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a fetch sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 checksum error |
| ext_count | output | BLK_W (3) | Valid extension blocks fetched |
| ddc_fifo_clr | output | 1 | Clear the receive FIFO |
| ddc_cmd_start | output | 1 | Issue a read command |
| ddc_segment | output | 8 | Segment of the command |
| ddc_offset | output | 8 | In-segment byte offset |
| ddc_count | output | CNT_W (5) | Byte count of the command |
| ddc_done | input | 1 | Command complete pulse |
| ddc_fifo_rd | output | 1 | Pop one byte from the FIFO |
| ddc_fifo_data | input | 8 | FIFO head byte |
| buf_we | output | 1 | Block buffer write enable |
| buf_blk | output | BLK_W (3) | Block index of the write |
| buf_addr | output | 7 | Byte index of the write |
| buf_data | output | 8 | Byte written |

## Verification
The bench keeps the default chunk size, block length, extension cap and retry limit. It lowers TIMEOUT_CYC to 60, so that a channel model that withholds its done pulse drives every attempt of a block into the timeout path within a few hundred cycles. The model answers each command after three cycles and can corrupt or drop chosen attempts of chosen blocks. This covers retried successes, exhausted retries on the base block and on an extension block, and the clamping of an oversized extension flag.

// File: rtl/edid_fetch_pkg.sv
package edid_fetch_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_ISSUE,
        ST_WAIT,
        ST_DRAIN,
        ST_CHECK,
        ST_FINISH
    } fetch_state_e;

    typedef enum logic [1:0] {
        FS_OK      = 2'd0,
        FS_TIMEOUT = 2'd1,
        FS_CSUM    = 2'd2
    } fetch_status_e;

endpackage

// File: rtl/edid_cmd_fmt.sv
module edid_cmd_fmt #(
    parameter int BLOCK_BYTES = 128,
    parameter int CHUNK_MAX   = 16,
    parameter int BLK_W       = 3,
    parameter int POS_W       = 8,
    parameter int CNT_W       = 5,
    parameter int OFF_W       = 10
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       segment,
    output logic [7:0]       offset,
    output logic [CNT_W-1:0] count
);
    logic [OFF_W-1:0] abs_off;
    logic [POS_W:0]   remain;

    always_comb begin
        abs_off = OFF_W'(blk) * OFF_W'(BLOCK_BYTES) + OFF_W'(pos);
        segment = 8'(abs_off >> 8);
        offset  = abs_off[7:0];
        remain  = (POS_W+1)'(BLOCK_BYTES) - (POS_W+1)'(pos);
        if (remain > (POS_W+1)'(CHUNK_MAX)) begin
            count = CNT_W'(CHUNK_MAX);
        end else begin
            count = CNT_W'(remain);
        end
    end
endmodule

// File: rtl/edid_wait_timer.sv
module edid_wait_timer #(
    parameter int TIMEOUT_CYC = 10_000_000,
    localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + CW'(1) : '0;
        expired = run && (cnt_q == CW'(TIMEOUT_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/edid_csum_acc.sv
module edid_csum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       add,
    input  logic [7:0] data,
    output logic       zero
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (clr)      sum_d = '0;
        else if (add) sum_d = sum_q + data;
        zero = (sum_q == 8'd0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/edid_fetch_seq.sv
module edid_fetch_seq
    import edid_fetch_pkg::*;
#(
    parameter int BLOCK_BYTES = 128,
    parameter int CHUNK_MAX   = 16,
    parameter int MAX_EXT     = 4,
    parameter int MAX_RETRY   = 2,
    parameter int TIMEOUT_CYC = 10_000_000,
    parameter int FLAG_POS    = 126,
    localparam int BLK_W   = $clog2(MAX_EXT + 1),
    localparam int POS_W   = $clog2(BLOCK_BYTES + 1),
    localparam int ADDR_W  = $clog2(BLOCK_BYTES),
    localparam int CNT_W   = $clog2(CHUNK_MAX + 1),
    localparam int TRY_W   = $clog2(MAX_RETRY + 2),
    localparam int OFF_RAW = $clog2((MAX_EXT + 1) * BLOCK_BYTES),
    localparam int OFF_W   = (OFF_RAW < 9) ? 9 : OFF_RAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [BLK_W-1:0]  ext_count,
    output logic              ddc_fifo_clr,
    output logic              ddc_cmd_start,
    output logic [7:0]        ddc_segment,
    output logic [7:0]        ddc_offset,
    output logic [CNT_W-1:0]  ddc_count,
    input  logic              ddc_done,
    output logic              ddc_fifo_rd,
    input  logic [7:0]        ddc_fifo_data,
    output logic              buf_we,
    output logic [BLK_W-1:0]  buf_blk,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data
);

    typedef struct packed {
        fetch_state_e     st;
        logic [BLK_W-1:0] blk;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] left;
        logic [TRY_W-1:0] tries;
        logic             tmo;
        logic [7:0]       flag;
        logic [BLK_W-1:0] lim;
        logic [BLK_W-1:0] ext;
        fetch_status_e    code;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             tmr_expired;
    logic             sum_zero;
    logic             sum_clr;
    logic [CNT_W-1:0] fmt_count;

    // Command field formatting from the current block and byte position
    edid_cmd_fmt #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .CHUNK_MAX   (CHUNK_MAX),
        .BLK_W       (BLK_W),
        .POS_W       (POS_W),
        .CNT_W       (CNT_W),
        .OFF_W       (OFF_W)
    ) u_fmt (
        .blk     (r_q.blk),
        .pos     (r_q.pos),
        .segment (ddc_segment),
        .offset  (ddc_offset),
        .count   (fmt_count)
    );

    edid_wait_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == ST_WAIT),
        .expired (tmr_expired)
    );

    assign sum_clr = (r_q.st == ST_CLR) && (r_q.pos == '0);

    edid_csum_acc u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sum_clr),
        .add   (r_q.st == ST_DRAIN),
        .data  (ddc_fifo_data),
        .zero  (sum_zero)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_CLR;
                    r_d.blk   = '0;
                    r_d.pos   = '0;
                    r_d.tries = '0;
                    r_d.tmo   = 1'b0;
                    r_d.lim   = '0;
                    r_d.ext   = '0;
                    r_d.code  = FS_OK;
                end
            end
            ST_CLR: begin
                r_d.st = ST_ISSUE;
            end
            ST_ISSUE: begin
                r_d.left = fmt_count;
                r_d.st   = ST_WAIT;
            end
            ST_WAIT: begin
                if (ddc_done) begin
                    r_d.st = ST_DRAIN;
                end else if (tmr_expired) begin
                    r_d.tmo = 1'b1;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_DRAIN: begin
                if (r_q.blk == '0 && r_q.pos == POS_W'(FLAG_POS)) begin
                    r_d.flag = ddc_fifo_data;
                end
                r_d.pos  = r_q.pos + POS_W'(1);
                r_d.left = r_q.left - CNT_W'(1);
                if (r_q.left == CNT_W'(1)) begin
                    if (r_q.pos + POS_W'(1) == POS_W'(BLOCK_BYTES)) r_d.st = ST_CHECK;
                    else                                            r_d.st = ST_CLR;
                end
            end
            ST_CHECK: begin
                if (!r_q.tmo && sum_zero) begin
                    r_d.tries = '0;
                    r_d.pos   = '0;
                    if (r_q.blk == '0) begin
                        if (r_q.flag > 8'(MAX_EXT)) r_d.lim = BLK_W'(MAX_EXT);
                        else                         r_d.lim = BLK_W'(r_q.flag);
                        if (r_q.flag == 8'd0) begin
                            r_d.st = ST_FINISH;
                        end else begin
                            r_d.blk = BLK_W'(1);
                            r_d.st  = ST_CLR;
                        end
                    end else begin
                        r_d.ext = r_q.blk;
                        if (r_q.blk == r_q.lim) begin
                            r_d.st = ST_FINISH;
                        end else begin
                            r_d.blk = r_q.blk + BLK_W'(1);
                            r_d.st  = ST_CLR;
                        end
                    end
                end else if (r_q.tries < TRY_W'(MAX_RETRY)) begin
                    r_d.tries = r_q.tries + TRY_W'(1);
                    r_d.pos   = '0;
                    r_d.tmo   = 1'b0;
                    r_d.st    = ST_CLR;
                end else begin
                    r_d.st = ST_FINISH;
                    if (r_q.blk == '0) begin
                        r_d.code = r_q.tmo ? FS_TIMEOUT : FS_CSUM;
                        r_d.ext  = '0;
                    end else begin
                        r_d.code = FS_OK;
                        r_d.ext  = r_q.blk - BLK_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, code: FS_OK, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy          = (r_q.st != ST_IDLE);
    assign done          = (r_q.st == ST_FINISH);
    assign status        = r_q.code;
    assign ext_count     = r_q.ext;
    assign ddc_fifo_clr  = (r_q.st == ST_CLR);
    assign ddc_cmd_start = (r_q.st == ST_ISSUE);
    assign ddc_count     = fmt_count;
    assign ddc_fifo_rd   = (r_q.st == ST_DRAIN);
    assign buf_we        = (r_q.st == ST_DRAIN);
    assign buf_blk       = r_q.blk;
    assign buf_addr      = r_q.pos[ADDR_W-1:0];
    assign buf_data      = ddc_fifo_data;

endmodule

// File: rtl/edid_fetch_seq_chk.sv
module edid_fetch_seq_chk #(
    parameter int CHUNK_MAX = 16,
    parameter int MAX_EXT   = 4,
    parameter int BLK_W     = 3,
    parameter int CNT_W     = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [1:0]       status,
    input logic [BLK_W-1:0] ext_count,
    input logic             ddc_fifo_clr,
    input logic             ddc_cmd_start,
    input logic [CNT_W-1:0] ddc_count
);
    assert_chunk_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ddc_cmd_start |-> (ddc_count != '0 && ddc_count <= CNT_W'(CHUNK_MAX)));

    assert_clear_before_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ddc_cmd_start |-> $past(ddc_fifo_clr));

    assert_ext_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ext_count <= BLK_W'(MAX_EXT));

    assert_base_err_no_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> ext_count == '0);

    assert_status_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd3);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind edid_fetch_seq edid_fetch_seq_chk #(
    .CHUNK_MAX (CHUNK_MAX),
    .MAX_EXT   (MAX_EXT),
    .BLK_W     (BLK_W),
    .CNT_W     (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .status        (status),
    .ext_count     (ext_count),
    .ddc_fifo_clr  (ddc_fifo_clr),
    .ddc_cmd_start (ddc_cmd_start),
    .ddc_count     (ddc_count)
);

// File: tb/edid_fetch_seq_tb.sv
module edid_fetch_seq_tb;

    localparam int TMO = 60;
    localparam int LAT = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       busy, done;
    logic [1:0] status;
    logic [2:0] ext_count;
    logic       ddc_fifo_clr, ddc_cmd_start, ddc_fifo_rd;
    logic [7:0] ddc_segment, ddc_offset;
    logic [4:0] ddc_count;
    logic       ddc_done = 1'b0;
    logic [7:0] ddc_fifo_data;
    logic       buf_we;
    logic [2:0] buf_blk;
    logic [6:0] buf_addr;
    logic [7:0] buf_data;

    always #10 clk = ~clk;

    edid_fetch_seq #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .status(status), .ext_count(ext_count),
        .ddc_fifo_clr(ddc_fifo_clr), .ddc_cmd_start(ddc_cmd_start),
        .ddc_segment(ddc_segment), .ddc_offset(ddc_offset), .ddc_count(ddc_count),
        .ddc_done(ddc_done), .ddc_fifo_rd(ddc_fifo_rd), .ddc_fifo_data(ddc_fifo_data),
        .buf_we(buf_we), .buf_blk(buf_blk), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] img [0:639];
    logic [7:0] cap [0:639];
    logic [7:0] fmem [0:15];
    int rptr = 0;
    int cor_left [0:4];
    int drop_left [0:4];
    int lat_cnt = 0;
    int pend_addr = 0;
    int pend_cnt = 0;
    bit pend_bad = 0;
    bit prev_clr = 0;
    int cmd_n = 0;
    bit seg1_seen = 0;
    int done_n = 0;

    typedef struct {
        logic [1:0] st;
        logic [2:0] ex;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    assign ddc_fifo_data = fmem[rptr[3:0]];

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Channel model: answers commands, optionally corrupting or dropping attempts
    always @(posedge clk) begin
        int a;
        int b;
        int exp_cnt;
        ddc_done <= 1'b0;
        if (ddc_fifo_clr)     rptr <= 0;
        else if (ddc_fifo_rd) rptr <= rptr + 1;
        if (lat_cnt == 1) begin
            for (int i = 0; i < 16; i++) begin
                if (i < pend_cnt)
                    fmem[i] <= img[pend_addr + i] ^ ((pend_bad && i == 0) ? 8'h01 : 8'h00);
            end
            ddc_done <= 1'b1;
        end
        if (lat_cnt > 0) lat_cnt <= lat_cnt - 1;
        if (ddc_cmd_start) begin
            cmd_n++;
            a = int'(ddc_segment) * 256 + int'(ddc_offset);
            b = a / 128;
            if (b > 4) b = 4;
            exp_cnt = (128 - (a % 128) > 16) ? 16 : 128 - (a % 128);
            check(int'(ddc_count) == exp_cnt, "R1 chunk count", int'(ddc_count), exp_cnt);
            check(prev_clr, "R3 fifo clear before command", int'(prev_clr), 1);
            if (ddc_segment == 8'd1 && ddc_offset == 8'd0) seg1_seen = 1;
            if (a % 128 == 0) begin
                pend_bad = 0;
                if (cor_left[b] > 0) begin
                    cor_left[b]--;
                    pend_bad = 1;
                end
                if (drop_left[b] > 0) begin
                    drop_left[b]--;
                    pend_addr = -1;
                end else begin
                    pend_addr = a;
                end
            end else if (pend_addr >= 0) begin
                pend_addr = a;
            end
            pend_cnt = int'(ddc_count);
            if (pend_addr >= 0) lat_cnt <= LAT;
        end
        prev_clr = ddc_fifo_clr;
    end

    always @(posedge clk) begin
        if (buf_we) cap[int'(buf_blk) * 128 + int'(buf_addr)] <= buf_data;
    end

    // Monitor: pops expected results and compares on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_n++;
            if (sb_q.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(status == e.st, {e.tag, " status"}, int'(status), int'(e.st));
                check(ext_count == e.ex, {e.tag, " ext_count"}, int'(ext_count), int'(e.ex));
                if (e.st == 2'd0) begin
                    int bad;
                    bad = 0;
                    for (int i = 0; i < (int'(e.ex) + 1) * 128; i++)
                        if (cap[i] !== img[i]) bad++;
                    check(bad == 0, "R9 R3 block buffer contents", bad, 0);
                end
            end
        end
    end

    task automatic build_img(input int flag, input int seed);
        for (int b = 0; b < 5; b++) begin
            logic [7:0] s;
            s = 8'd0;
            for (int i = 0; i < 127; i++) begin
                logic [7:0] v;
                v = 8'((b * 37 + i * 11 + seed) & 255);
                if (b == 0 && i == 126) v = 8'(flag);
                img[b * 128 + i] = v;
                s = s + v;
            end
            img[b * 128 + 127] = 8'd0 - s;
        end
        for (int i = 0; i < 640; i++) cap[i] = 8'hxx;
        for (int b = 0; b < 5; b++) begin
            cor_left[b] = 0;
            drop_left[b] = 0;
        end
    endtask

    task automatic run_case(input logic [1:0] st, input logic [2:0] ex, input string tag);
        exp_t e;
        e.st = st;
        e.ex = ex;
        e.tag = tag;
        sb_q.push_back(e);
        cmd_n = 0;
        seg1_seen = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (sb_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (done never reached)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        build_img(0, 5);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R10 reset idle", int'(busy), 0);
        check(!ddc_cmd_start && !ddc_fifo_clr && !buf_we, "R9 reset quiet outputs", int'(ddc_cmd_start), 0);

        // R1: base block only
        build_img(0, 5);
        run_case(2'd0, 3'd0, "R1 base only");
        check(cmd_n == 8, "R1 commands per block", cmd_n, 8);

        // R2: two extensions, block 2 starts at segment 1 offset 0
        build_img(2, 9);
        run_case(2'd0, 3'd2, "R2 two extensions");
        check(seg1_seen, "R2 segment 1 offset 0 issued", int'(seg1_seen), 1);
        check(cmd_n == 24, "R1 commands for three blocks", cmd_n, 24);

        // R6: flag 7 clamps to 4
        build_img(7, 3);
        run_case(2'd0, 3'd4, "R6 clamp extensions");
        check(cmd_n == 40, "R6 five blocks fetched", cmd_n, 40);

        // R5: base corrupted twice, third attempt good
        build_img(1, 11);
        cor_left[0] = 2;
        run_case(2'd0, 3'd1, "R5 retry then ok");
        check(cmd_n == 32, "R5 re-read commands", cmd_n, 32);

        // R8: base corrupted on all three attempts
        build_img(3, 2);
        cor_left[0] = 3;
        run_case(2'd2, 3'd0, "R8 base checksum error");
        check(cmd_n == 24, "R5 three attempts only", cmd_n, 24);

        // R7: extension 2 fails every attempt
        build_img(4, 6);
        cor_left[2] = 3;
        run_case(2'd0, 3'd1, "R7 extension failure stops");

        // R4: base never answered
        build_img(0, 1);
        drop_left[0] = 3;
        run_case(2'd1, 3'd0, "R4 R8 base timeout");
        check(cmd_n == 3, "R4 one command per timed-out attempt", cmd_n, 3);

        // R4 R5: one timeout then recovery
        build_img(2, 4);
        drop_left[1] = 1;
        run_case(2'd0, 3'd2, "R4 R5 timeout then ok");

        // R10: start while busy is ignored
        build_img(1, 8);
        done_n = 0;
        fork
            run_case(2'd0, 3'd1, "R10 start while busy");
            begin
                repeat (40) @(negedge clk);
                check(busy, "R10 busy during run", int'(busy), 1);
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        join
        repeat (400) @(negedge clk);
        check(done_n == 1, "R10 single done", done_n, 1);
        check(!busy, "R10 idle after done", int'(busy), 0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule